// File: doc/BRIEF.md
# Posted-Write Acknowledge Tracker

This block sits beside a transmitter that sends posted writes (full-line and masked) to a downstream unit and receives one acknowledge pulse back for each of them. The transmitter decodes its own header-valid cycles and raises a one-cycle write-issued pulse for every write header it sends. The downstream unit raises a one-cycle acknowledge pulse for every write it has completed. The tracker pairs the two streams in issue order. It keeps a count of the writes still in flight, and it drops a credit signal that stalls the transmitter when the in-flight limit is reached.

Each write is stamped with the cycle in which it was issued. A small first-in first-out store holds these stamps, so the age of the oldest outstanding write is always known. Four sticky error flags report protocol violations. An acknowledge may arrive too soon after its write. An acknowledge may arrive when no write is outstanding. A write may be issued while no credit is left. The oldest write may wait longer than the allowed maximum. The flags stay set until the clear input is pulsed.

Latency is measured as the acknowledge cycle minus the issue cycle of the write it retires. Every output is registered, so each effect shows on the ports in the cycle after the input that caused it.

Top module: `pwack_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, outstanding_o is 0, credit_ok_o is 1 and all four error flags are 0.
- R2: An accepted write raises outstanding_o by one in the next cycle. An acknowledge with at least one write outstanding lowers it by one. A write and an acknowledge in the same cycle leave it unchanged.
- R3: credit_ok_o is 0 exactly when outstanding_o equals MAX_OUT (default 16), and 1 otherwise.
- R4: A write issued while MAX_OUT writes are outstanding, with no acknowledge in the same cycle, sets err_overflow_o. That write is discarded and outstanding_o does not change.
- R5: An acknowledge with no write outstanding and no write in the same cycle sets err_orphan_o, and outstanding_o stays 0.
- R6: Acknowledges retire writes oldest first. If the retired write's latency is below MIN_LAT (default 2), err_early_o is set. An acknowledge in the same cycle as a write, with nothing outstanding, retires that write with latency 0.
- R7: If the oldest outstanding write reaches latency MAX_LAT+1 (default 48001), err_timeout_o is set in the following cycle. An acknowledge at latency MAX_LAT exactly does not set it.
- R8: Each error flag stays set until err_clr_i is pulsed. When a clear and a new event for the same flag occur in the same cycle, that flag ends up set. The flags are independent of one another.
- R9: Writes acknowledged at latencies from MIN_LAT to MAX_LAT inclusive set no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_issue_i | input | 1 | One-cycle pulse per posted write header sent |
| ack_vld_i | input | 1 | One-cycle acknowledge pulse from the downstream unit |
| err_clr_i | input | 1 | Pulse to clear all sticky error flags |
| outstanding_o | output | $clog2(MAX_OUT+1) | Number of writes awaiting acknowledge |
| credit_ok_o | output | 1 | High while another write may be issued |
| err_early_o | output | 1 | Sticky: acknowledge latency below minimum |
| err_orphan_o | output | 1 | Sticky: acknowledge with nothing outstanding |
| err_overflow_o | output | 1 | Sticky: write issued with no credit |
| err_timeout_o | output | 1 | Sticky: oldest write exceeded maximum latency |

## Verification
The properties assume that every input has a known 0 or 1 value on every clock edge after reset. They also assume that a pulse held high for several cycles means one event per cycle. During reset they are disabled, and the reset-state property alone covers that window. The stimulus changes inputs only shortly after a rising edge and keeps every value known. It resets the block between sweep patterns, so each pattern starts from an empty queue. The sweeps run a reduced configuration (four credits, a twenty-cycle maximum latency), which lets every latency and every fill level be reached with few cycles.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  localparam int unsigned NUM_ERR = 4;

  typedef enum logic [1:0] {
    EV_EARLY    = 2'd0,
    EV_ORPHAN   = 2'd1,
    EV_OVERFLOW = 2'd2,
    EV_TIMEOUT  = 2'd3
  } err_idx_e;
endpackage

// File: rtl/pwt_ts_fifo.sv
module pwt_ts_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TS_W  = 17
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [TS_W-1:0] ts_i,
  output logic [TS_W-1:0] head_ts_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TS_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push_i) mem[wp_q] <= ts_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push_i) wp_q <= bump(wp_q);
      if (pop_i)  rp_q <= bump(rp_q);
    end
  end

  assign head_ts_o = mem[rp_q];
endmodule

// File: rtl/pwt_credit_ctr.sv
module pwt_credit_ctr #(
  parameter int unsigned MAX_OUT = 16,
  parameter int unsigned CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             credit_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_OUT);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic             credit_q;

  always_comb begin
    cnt_nx = cnt_q;
    if (inc_i && !dec_i)      cnt_nx = cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      credit_q <= 1'b1;
    end else begin
      cnt_q    <= cnt_nx;
      credit_q <= (cnt_nx < LIMIT);
    end
  end

  assign cnt_o    = cnt_q;
  assign credit_o = credit_q;
  assign empty_o  = (cnt_q == '0);
  assign full_o   = (cnt_q == LIMIT);
endmodule

// File: rtl/pwt_err_flags.sv
module pwt_err_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst) f_q <= 1'b0;
      else     f_q <= set_i[g] | (f_q & ~clr_i);
    end
    assign flag_o[g] = f_q;
  end
endmodule

// File: rtl/pwack_tracker.sv
module pwack_tracker #(
  parameter int unsigned MAX_OUT = 16,
  parameter int unsigned MIN_LAT = 2,
  parameter int unsigned MAX_LAT = 48000
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_issue_i,
  input  logic                         ack_vld_i,
  input  logic                         err_clr_i,
  output logic [$clog2(MAX_OUT+1)-1:0] outstanding_o,
  output logic                         credit_ok_o,
  output logic                         err_early_o,
  output logic                         err_orphan_o,
  output logic                         err_overflow_o,
  output logic                         err_timeout_o
);
  import pwt_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);
  localparam int unsigned TS_W  = $clog2(MAX_LAT + 2) + 1;
  localparam logic [TS_W-1:0] MIN_AGE = TS_W'(MIN_LAT);
  localparam logic [TS_W-1:0] MAX_AGE = TS_W'(MAX_LAT);

  logic [TS_W-1:0]    now_q, head_ts, head_age;
  logic               empty, full;
  logic               bypass, pop, push;
  logic [NUM_ERR-1:0] ev, flags;

  // free-running issue stamp
  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + 1'b1;
  end

  assign head_age = now_q - head_ts;

  // event decode
  assign bypass = wr_issue_i & ack_vld_i & empty;
  assign pop    = ack_vld_i & ~empty;
  assign push   = wr_issue_i & ~bypass & (~full | pop);

  always_comb begin
    ev               = '0;
    ev[EV_EARLY]     = (bypass & (MIN_LAT > 0)) | (pop & (head_age < MIN_AGE));
    ev[EV_ORPHAN]    = ack_vld_i & empty & ~wr_issue_i;
    ev[EV_OVERFLOW]  = wr_issue_i & full & ~ack_vld_i;
    ev[EV_TIMEOUT]   = ~empty & (head_age > MAX_AGE);
  end

  pwt_ts_fifo #(.DEPTH(MAX_OUT), .TS_W(TS_W)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_i    (push),
    .pop_i     (pop),
    .ts_i      (now_q),
    .head_ts_o (head_ts)
  );

  pwt_credit_ctr #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .inc_i    (push),
    .dec_i    (pop),
    .cnt_o    (outstanding_o),
    .credit_o (credit_ok_o),
    .empty_o  (empty),
    .full_o   (full)
  );

  pwt_err_flags #(.N(NUM_ERR)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (err_clr_i),
    .set_i  (ev),
    .flag_o (flags)
  );

  assign err_early_o    = flags[EV_EARLY];
  assign err_orphan_o   = flags[EV_ORPHAN];
  assign err_overflow_o = flags[EV_OVERFLOW];
  assign err_timeout_o  = flags[EV_TIMEOUT];
endmodule

// File: rtl/pwt_checker.sv
module pwt_checker #(
  parameter int unsigned MAX_OUT = 16,
  parameter int unsigned CNT_W   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr,
  input logic             ack,
  input logic             clr,
  input logic [CNT_W-1:0] cnt,
  input logic             credit,
  input logic             e_early,
  input logic             e_orphan,
  input logic             e_ovf,
  input logic             e_tmo
);
  logic [3:0] errs;
  assign errs = {e_tmo, e_ovf, e_orphan, e_early};

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (cnt == '0 && credit && errs == '0));                                  // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_OUT));                                                       // R2
  AST_BALANCE: assert property (@(posedge clk) disable iff (rst)
    (wr && ack) |=> cnt == $past(cnt));                                            // R2
  AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    credit == (cnt != CNT_W'(MAX_OUT)));                                           // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr && !ack && cnt == CNT_W'(MAX_OUT)) |=> (e_ovf && cnt == CNT_W'(MAX_OUT))); // R4
  AST_ORPHAN_ACK: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr && cnt == '0) |=> (e_orphan && cnt == '0));                        // R5
  AST_SAME_CYCLE_EARLY: assert property (@(posedge clk) disable iff (rst)
    (wr && ack && cnt == '0) |=> e_early);                                         // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((errs & $past(errs)) == $past(errs)));                               // R8
endmodule

bind pwack_tracker pwt_checker #(.MAX_OUT(MAX_OUT), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr       (wr_issue_i),
  .ack      (ack_vld_i),
  .clr      (err_clr_i),
  .cnt      (outstanding_o),
  .credit   (credit_ok_o),
  .e_early  (err_early_o),
  .e_orphan (err_orphan_o),
  .e_ovf    (err_overflow_o),
  .e_tmo    (err_timeout_o)
);

// File: tb/tb_pwack_tracker.sv
`timescale 1ns/1ps
module tb_pwack_tracker;
  localparam int MAXO = 4;
  localparam int MINL = 2;
  localparam int MAXL = 20;
  localparam int CW   = $clog2(MAXO + 1);

  logic clk = 1'b0;
  logic rst, wr, ack, clr;
  logic [CW-1:0] cnt;
  logic credit, e_early, e_orphan, e_ovf, e_tmo;

  always #2.5 clk = ~clk;

  pwack_tracker #(.MAX_OUT(MAXO), .MIN_LAT(MINL), .MAX_LAT(MAXL)) dut (
    .clk(clk), .rst(rst), .wr_issue_i(wr), .ack_vld_i(ack), .err_clr_i(clr),
    .outstanding_o(cnt), .credit_ok_o(credit), .err_early_o(e_early),
    .err_orphan_o(e_orphan), .err_overflow_o(e_ovf), .err_timeout_o(e_tmo)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int q[$];
  int cyc;
  bit m_early, m_orphan, m_ovf, m_tmo;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference: in-order pairing, latency = ack cycle - issue cycle
  task automatic model(input bit w, input bit a, input bit c);
    bit emp, ful, byp, pop, push, ev_e, ev_o, ev_v, ev_t;
    int age;
    emp  = (q.size() == 0);
    ful  = (q.size() == MAXO);
    age  = emp ? 0 : cyc - q[0];
    byp  = w && a && emp;
    pop  = a && !emp;
    push = w && !byp && (!ful || pop);
    ev_e = byp || (pop && age < MINL);
    ev_o = a && emp && !w;
    ev_v = w && ful && !a;
    ev_t = !emp && age > MAXL;
    if (pop)  void'(q.pop_front());
    if (push) q.push_back(cyc);
    m_early  = (m_early  && !c) || ev_e;
    m_orphan = (m_orphan && !c) || ev_o;
    m_ovf    = (m_ovf    && !c) || ev_v;
    m_tmo    = (m_tmo    && !c) || ev_t;
    cyc++;
  endtask

  task automatic compare_all();
    chk("R2 outstanding count", int'(cnt), q.size());
    chk("R3 credit", int'(credit), int'(q.size() < MAXO));
    chk("R4 overflow flag", int'(e_ovf), int'(m_ovf));
    chk("R5 orphan flag", int'(e_orphan), int'(m_orphan));
    chk("R6 early flag", int'(e_early), int'(m_early));
    chk("R7 timeout flag", int'(e_tmo), int'(m_tmo));
  endtask

  task automatic step(input bit w, input bit a, input bit c);
    wr = w; ack = a; clr = c;
    model(w, a, c);
    @(posedge clk); #1;
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1; wr = 0; ack = 0; clr = 0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 0;
    q.delete(); cyc = 0;
    m_early = 0; m_orphan = 0; m_ovf = 0; m_tmo = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 count after reset", int'(cnt), 0);
    chk("R1 credit after reset", int'(credit), 1);
    chk("R1 flags after reset", int'({e_early, e_orphan, e_ovf, e_tmo}), 0);

    // latency sweep: one write acknowledged after d cycles
    for (int d = 0; d <= MAXL + 3; d++) begin
      do_reset();
      if (d == 0) step(1, 1, 0);
      else begin
        step(1, 0, 0);
        for (int k = 1; k < d; k++) step(0, 0, 0);
        step(0, 1, 0);
      end
      step(0, 0, 0);
      if (d >= MINL && d <= MAXL)
        chk("R9 legal latency leaves flags clear",
            int'({e_early, e_orphan, e_ovf, e_tmo}), 0);
      if (d == MAXL) chk("R7 ack at max latency no timeout", int'(e_tmo), 0);
    end

    // fill sweep: n back-to-back writes, then spaced acknowledges
    for (int n = 0; n <= MAXO + 2; n++) begin
      do_reset();
      for (int k = 0; k < n; k++) step(1, 0, 0);
      step(0, 0, 0);
      for (int k = 0; k < n; k++) step(0, 1, 0);
      step(0, 0, 0);
    end

    // write and ack together while full
    do_reset();
    for (int k = 0; k < MAXO; k++) step(1, 0, 0);
    step(0, 0, 0); step(0, 0, 0);
    step(1, 1, 0);
    chk("R2 full with write+ack unchanged", int'(cnt), MAXO);

    // R8: clear with coincident orphan event keeps orphan, clears others
    do_reset();
    step(0, 1, 0);
    step(1, 0, 0);
    step(0, 1, 0);
    chk("R8 orphan held before clear", int'(e_orphan), 1);
    chk("R8 early held before clear", int'(e_early), 1);
    step(0, 1, 1);
    chk("R8 clear loses to new orphan", int'(e_orphan), 1);
    chk("R8 clear drops early", int'(e_early), 0);
    step(0, 0, 1);
    chk("R8 plain clear", int'(e_orphan), 0);

    // exhaustive 4-cycle input patterns
    for (int p = 0; p < 256; p++) begin
      do_reset();
      for (int k = 0; k < 4; k++) step(p[2*k], p[2*k+1], 0);
      for (int k = 0; k < 3; k++) step(0, 0, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule